// File: doc/BRIEF.md
# Two-Phase Handshake Event FIFO

This block buffers up to four 40-bit event words between a producer and a consumer. Both sides use transition signalling with bundled data. A side raises an event by flipping its wire, and a flip in either direction counts the same. The producer places a word on the data bus and flips its request wire. The FIFO stores the word and flips its write acknowledge to match. On the far side, the FIFO puts the oldest word on the output bus and flips its read request. It then waits for the consumer to flip the read acknowledge before it shows the next word.

The model is synchronous. Incoming request and acknowledge wires pass through two synchroniser flops, and a third flop detects the transition. A word written into an empty FIFO goes straight to the output register without passing through storage. A write that arrives while the FIFO is full stays pending, and its acknowledge is sent once a slot frees. The producer must hold the data stable from its request flip until the matching acknowledge flip.

Top module: `toggle_event_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, `wr_ack_o`, `rd_req_o` and `rd_data_o` are all zero and the FIFO holds no word.
- R2: Each transition of `wr_req_i`, rising or falling, produces exactly one transition of `wr_ack_o`, after which `wr_ack_o` equals `wr_req_i`. `wr_ack_o` never flips while the two levels are already equal.
- R3: When the FIFO is empty and no word is outstanding on the output, a write is seen on the third rising clock edge after the `wr_req_i` transition, and no earlier. On that edge `wr_ack_o` flips, `rd_req_o` flips, and `rd_data_o` carries the word.
- R4: `rd_req_o` flips only when the previous presentation has been acknowledged, which means `rd_ack_i` equals `rd_req_o`.
- R5: `rd_data_o` holds its value on every cycle in which `rd_req_o` does not flip.
- R6: The FIFO holds four words, and the word on the output bus counts as one of them. With four words held, a new write request gets no acknowledge until the consumer acknowledges a word. Once that happens, the pending write is acknowledged.
- R7: Words leave in the order they were written, with their value unchanged.
- R8: Changes on `wr_data_i` without a `wr_req_i` transition produce no acknowledge and no read request.
- R9: `rd_req_o` never flips unless at least one accepted word has not yet been presented.
- R10: When further words are stored, a `rd_ack_i` transition leads to the next word on `rd_data_o` together with a `rd_req_o` flip on the third rising clock edge after it, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write request, each transition offers one word |
| wr_data_i | input | 40 | Write word, stable from request flip to acknowledge flip |
| wr_ack_o | output | 1 | Write acknowledge, flips once the word is accepted |
| rd_req_o | output | 1 | Read request, flips when a new word is presented |
| rd_data_o | output | 40 | Presented word |
| rd_ack_i | input | 1 | Read acknowledge, flips when the consumer has taken the word |

## Verification
The hardest state to reach is a write that arrives while the FIFO is full and must wait for space. It is reached only when the consumer stalls long enough for three stored words to build up behind the presented one. A directed sequence holds back the read acknowledge while four words are written and a fifth request is raised. It then checks that this fifth acknowledge stays withheld for many cycles and follows shortly after a single read acknowledge. A randomised phase then runs producer and consumer in parallel with random gaps, so that the FIFO repeatedly passes through the empty, bypass and full states.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
    localparam int DEF_WORD_W = 40;
    localparam int DEF_DEPTH  = 4;
    localparam int DEF_SYNC   = 2;

    // Shared state of one transition detector: synchroniser chain plus history flop.
    typedef struct packed {
        logic [DEF_SYNC:0] sh;
    } sync_t;

    function automatic logic flipped(input logic a, input logic b);
        return a ^ b;
    endfunction
endpackage

// File: rtl/tpf_edge.sv
module tpf_edge
    import tpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic ev_o
);
    sync_t q, d;

    always_comb begin
        d    = q;
        d.sh = {q.sh[DEF_SYNC-1:0], lvl_i};
        ev_o = flipped(q.sh[DEF_SYNC], q.sh[DEF_SYNC-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tpf_ring.sv
module tpf_ring #(
    parameter int W     = 40,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [W-1:0]                 data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } ring_t;

    ring_t q, d;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push_i) begin
            d.mem[q.wp] = data_i;
            d.wp        = step(q.wp);
        end
        if (pop_i) begin
            d.rp = step(q.rp);
        end
        case ({push_i, pop_i})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_o = q.mem[q.rp];
    assign cnt_o  = q.cnt;
endmodule

// File: rtl/toggle_event_fifo.sv
module toggle_event_fifo
    import tpf_pkg::*;
#(
    parameter int W     = DEF_WORD_W,
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req_i,
    input  logic [W-1:0] wr_data_i,
    output logic         wr_ack_o,
    output logic         rd_req_o,
    output logic [W-1:0] rd_data_o,
    input  logic         rd_ack_i
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW:0] FULL_AT = (CW+1)'(DEPTH);

    typedef struct packed {
        logic         pend;
        logic         wr_ack;
        logic         rd_req;
        logic         out_valid;
        logic [W-1:0] out_data;
    } ctl_t;

    ctl_t q, d;

    logic          wr_ev, rd_ev;
    logic [W-1:0]  head;
    logic [CW-1:0] cnt;
    logic          push, pop, bypass, store, want, full, out_free;
    logic [CW:0]   occ;

    // One transition detector per incoming signalling wire.
    tpf_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .lvl_i(wr_req_i), .ev_o(wr_ev));
    tpf_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .lvl_i(rd_ack_i), .ev_o(rd_ev));

    tpf_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (store),
        .data_i (wr_data_i),
        .pop_i  (pop),
        .head_o (head),
        .cnt_o  (cnt)
    );

    always_comb begin
        d        = q;
        want     = q.pend | wr_ev;
        occ      = {1'b0, cnt} + (CW+1)'(q.out_valid);
        full     = (occ >= FULL_AT);
        push     = want & ~full;
        out_free = ~q.out_valid | rd_ev;
        pop      = out_free & (cnt != '0);
        bypass   = out_free & (cnt == '0) & push;
        store    = push & ~bypass;

        d.pend   = want & ~push;
        d.wr_ack = q.wr_ack ^ push;

        if (pop) begin
            d.out_data  = head;
            d.rd_req    = ~q.rd_req;
            d.out_valid = 1'b1;
        end else if (bypass) begin
            d.out_data  = wr_data_i;
            d.rd_req    = ~q.rd_req;
            d.out_valid = 1'b1;
        end else if (rd_ev) begin
            d.out_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ack_o  = q.wr_ack;
    assign rd_req_o  = q.rd_req;
    assign rd_data_o = q.out_data;
endmodule

// File: rtl/tpf_evfifo_chk.sv
module tpf_evfifo_chk #(
    parameter int W     = 40,
    parameter int DEPTH = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_req_i,
    input logic         wr_ack_o,
    input logic         rd_req_o,
    input logic [W-1:0] rd_data_o,
    input logic         rd_ack_i
);
    localparam int CW = $clog2(DEPTH + 1) + 2;
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    logic          wr_ack_p, rd_req_p, rd_ack_p;
    logic [CW-1:0] held_q, unshown_q;
    logic          wt, rt, at;

    assign wt = wr_ack_o ^ wr_ack_p;
    assign rt = rd_req_o ^ rd_req_p;
    assign at = rd_ack_i ^ rd_ack_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ack_p  <= 1'b0;
            rd_req_p  <= 1'b0;
            rd_ack_p  <= 1'b0;
            held_q    <= '0;
            unshown_q <= '0;
        end else begin
            wr_ack_p  <= wr_ack_o;
            rd_req_p  <= rd_req_o;
            rd_ack_p  <= rd_ack_i;
            held_q    <= held_q + CW'(wt) - CW'(at);
            unshown_q <= unshown_q + CW'(wt) - CW'(rt);
        end
    end

    // R2
    wr_ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack_o != $past(wr_ack_o)) |-> ($past(wr_req_i) != $past(wr_ack_o)));

    // R4
    rd_req_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o != $past(rd_req_o)) |-> ($past(rd_ack_i) == $past(rd_req_o)));

    // R5
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o == $past(rd_req_o)) |-> $stable(rd_data_o));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q + CW'(wt)) <= LIMIT);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt |-> ((unshown_q + CW'(wt)) != '0));
endmodule

bind toggle_event_fifo tpf_evfifo_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req_i  (wr_req_i),
    .wr_ack_o  (wr_ack_o),
    .rd_req_o  (rd_req_o),
    .rd_data_o (rd_data_o),
    .rd_ack_i  (rd_ack_i)
);

// File: tb/toggle_event_fifo_tb_top.sv
module toggle_event_fifo_tb_top;
    localparam int W = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_req = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_ack, rd_req;
    logic [W-1:0] rd_data;
    logic         rd_ack = 1'b0;

    always #10 clk = ~clk;

    toggle_event_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_data_i(wr_data),
        .wr_ack_o(wr_ack), .rd_req_o(rd_req), .rd_data_o(rd_data), .rd_ack_i(rd_ack)
    );

    int unsigned n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [W-1:0] model_q[$];

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int unsigned idx);
        logic [31:0] lo;
        lo = idx * 32'h9E37_79B1;
        return {idx[7:0], lo};
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [7:0] hi;
        hi = 8'($urandom());
        return {hi, $urandom()};
    endfunction

    task automatic do_write(input logic [W-1:0] w, input string req);
        @(negedge clk);
        wr_data = w;
        model_q.push_back(w);
        wr_req = ~wr_req;
        for (int i = 0; i < 300 && wr_ack != wr_req; i++) @(negedge clk);
        chk(wr_ack == wr_req, req, W'(wr_ack), W'(wr_req));
    endtask

    task automatic read_one(input int delay);
        logic [W-1:0] exp;
        for (int i = 0; i < 300 && rd_req == rd_ack; i++) @(negedge clk);
        exp = (model_q.size() != 0) ? model_q.pop_front() : '1;
        // R7: order and value
        chk(rd_req != rd_ack && rd_data == exp, "R7 order", rd_data, exp);
        repeat (delay) @(negedge clk);
        rd_ack = ~rd_ack;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] e;
        e = W'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        chk(!wr_ack && !rd_req && rd_data == '0, "R1 in reset", {wr_ack, rd_req, rd_data[37:0]}, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!wr_ack && !rd_req && rd_data == '0, "R1 after reset", {wr_ack, rd_req, rd_data[37:0]}, '0);

        // R8: data wiggles without a request transition
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            wr_data = rnd_word();
        end
        repeat (4) @(negedge clk);
        chk(!wr_ack && !rd_req, "R8 data ignored", W'({wr_ack, rd_req}), '0);

        // R3: bypass latency into an empty FIFO
        @(negedge clk);
        wr_data = pat(1);
        model_q.push_back(pat(1));
        wr_req = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!wr_ack && !rd_req, "R3 not before third edge", W'({wr_ack, rd_req}), '0);
        @(posedge clk);
        @(negedge clk);
        chk(wr_ack == 1'b1, "R2 rising request acked", W'(wr_ack), W'(1));
        chk(rd_req == 1'b1 && rd_data == pat(1), "R3 fast forward", rd_data, pat(1));

        // R2: falling request transition counts too
        do_write(pat(2), "R2 falling request acked");
        chk(wr_ack == 1'b0, "R2 ack level follows", W'(wr_ack), '0);
        chk(rd_req == 1'b1 && rd_data == pat(1), "R5 output held", rd_data, pat(1));

        // R6: fill to four words, then one more request waits
        do_write(pat(3), "R6 third word");
        do_write(pat(4), "R6 fourth word");
        @(negedge clk);
        wr_data = pat(5);
        model_q.push_back(pat(5));
        wr_req = ~wr_req;
        repeat (20) @(negedge clk);
        chk(wr_ack != wr_req, "R6 ack withheld when full", W'(wr_ack), W'(~wr_req));

        // R10: consumer frees a slot; next word on third edge
        e = model_q.pop_front();
        chk(rd_data == e, "R7 first word", rd_data, e);
        rd_ack = ~rd_ack;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rd_req == 1'b1, "R10 not before third edge", W'(rd_req), W'(1));
        @(posedge clk);
        @(negedge clk);
        chk(rd_req == 1'b0 && rd_data == pat(2), "R10 next word", rd_data, pat(2));
        for (int i = 0; i < 6 && wr_ack != wr_req; i++) @(negedge clk);
        chk(wr_ack == wr_req, "R6 pending ack released", W'(wr_ack), W'(wr_req));

        for (int i = 0; i < 4; i++) read_one(i);
        repeat (8) @(negedge clk);
        chk(rd_req == rd_ack, "R9 no extra request when empty", W'(rd_req), W'(rd_ack));

        // Random producer and consumer in parallel
        fork
            begin
                for (int i = 0; i < 300; i++) begin
                    repeat ($urandom_range(0, 5)) @(negedge clk);
                    do_write(rnd_word(), "R2 random write");
                end
            end
            begin
                for (int i = 0; i < 300; i++) read_one($urandom_range(0, 7));
            end
        join

        repeat (10) @(negedge clk);
        chk(rd_req == rd_ack && model_q.size() == 0, "R9 drained", W'(model_q.size()), '0);
        wr_data = rnd_word();
        repeat (10) @(negedge clk);
        chk(rd_req == rd_ack && wr_ack == wr_req, "R8 idle data ignored", W'(rd_req), W'(rd_ack));

        finished = 1;
        summary();
        $finish;
    end
endmodule